// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers the interrupt flags of a small 8-bit microcontroller core. There are six sources: two external request pins, three timer overflow flags and one serial port flag. Each source has an enable bit, and one global enable bit gates them all. A priority register places each source in either a high or a low level. The block chooses one winner, presents its fixed vector address to the core and raises a request strobe. That strobe holds until the core acknowledges it.

The block records which levels are in service, so nesting stays legal: a high-level request can interrupt a low-level handler, and nothing else can preempt. A return-from-interrupt pulse ends the handler at the highest active level. Requests are sampled only on a machine-cycle strobe. The enable and priority registers are reached over a plain byte bus with a combinational read port. The timers, the serial logic and instruction fetch are outside the block; their flags arrive as inputs.

Top module: `irq_vector_ctl`

## Requirements
- R1: After synchronous reset both registers read 0x00, `irq_req` is 0, `irq_vec` is 0x0000, and no level is in service.
- R2: The enable register is at byte address 0xA8: bit 7 is the global enable, bit 6 always reads 0, and bits 5..0 enable the sources. The priority register is at 0xB8: bits 7..6 always read 0, and a 1 in bits 5..0 puts that source in the high level. Source bit indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R3: The vector address is 0x0003 + 8 × (source index): 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B.
- R4: A source is requested only when its own enable bit and the global enable bit are both 1; otherwise `irq_req` stays 0.
- R5: A pending high-level source wins over every pending low-level source, whatever their indices.
- R6: Within one level, the pending source with the lowest index wins.
- R7: A high-level request is granted while only a low-level handler is in service. A low-level request is not granted while a low-level handler is in service. No request is granted while a high-level handler is in service.
- R8: A `reti` pulse clears the high in-service level if it is set, and otherwise clears the low level.
- R9: No new request is granted in a cycle in which `reti` is 1.
- R10: `src_req` is sampled only in cycles in which `cyc_stb` is 1; a change between strobes has no effect.
- R11: Once raised, `irq_req` stays 1 and `irq_vec` stays unchanged until `irq_ack` is seen. `irq_req` falls on the next edge, and the granted level becomes in service.
- R12: When `cyc_stb` samples an eligible request at clock edge k and nothing blocks it, `irq_req` is 1 after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Machine-cycle strobe that samples the request flags |
| src_req | input | 6 | Source flags, index 0 external 0 up to index 5 timer 2 |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the granted source |
| irq_ack | input | 1 | Core acknowledge of the request |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
A vector table sets one enable, priority and request pattern per row. Single-source rows check each vector address. Rows with all sources at one level test the order within a level. Rows with mixed priority show that level outranks index, and masked rows separate the global gate from the per-source gates.

Directed sequences cover four further cases. The first builds low-then-high nesting and checks that reti unwinds one level at a time. The second holds requests between strobes. The third places a reti pulse in the cycle where a grant would otherwise be issued. The fourth holds an unacknowledged request and checks that the vector does not move.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 6;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
    endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter logic [7:0] EN_ADDR  = 8'hA8,
    parameter logic [7:0] PRI_ADDR = 8'hB8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic [NSRC-1:0] en_mask,
    output logic            glob_en,
    output logic [NSRC-1:0] prio
);
    localparam logic [7:0] EN_KEEP  = 8'h80 | 8'((1 << NSRC) - 1);
    localparam logic [7:0] PRI_KEEP = 8'((1 << NSRC) - 1);

    logic [7:0] en_q;
    logic [7:0] pri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 8'h00;
            pri_q <= 8'h00;
        end else if (bus_wr) begin
            if (bus_addr == EN_ADDR)  en_q  <= bus_wdata & EN_KEEP;
            if (bus_addr == PRI_ADDR) pri_q <= bus_wdata & PRI_KEEP;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == EN_ADDR)       bus_rdata = en_q;
        else if (bus_addr == PRI_ADDR) bus_rdata = pri_q;
    end

    assign en_mask = en_q[NSRC-1:0];
    assign glob_en = en_q[7];
    assign prio    = pri_q[NSRC-1:0];

    // R1
    reset_clears_regs_chk: assert property (@(posedge clk)
        rst |=> (en_q == 8'h00 && pri_q == 8'h00));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] cand,
    input  logic            lvl_hi,
    output pick_t           pick
);
    always_comb begin
        pick    = '0;
        pick.hi = lvl_hi;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker (
    input  logic clk,
    input  logic rst,
    input  logic set_hi,
    input  logic set_lo,
    input  logic reti,
    output logic insvc_hi,
    output logic insvc_lo
);
    logic hi_q, lo_q;
    logic hi_n, lo_n;

    always_comb begin
        hi_n = hi_q;
        lo_n = lo_q;
        if (reti) begin
            if (hi_q) hi_n = 1'b0;
            else      lo_n = 1'b0;
        end
        if (set_hi) hi_n = 1'b1;
        if (set_lo) lo_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign insvc_hi = hi_q;
    assign insvc_lo = lo_q;

    // R8
    reti_unwinds_one_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && hi_q && lo_q && !set_hi && !set_lo) |=> (!hi_q && lo_q));
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_pkg::*;
#(
    parameter logic [7:0] EN_ADDR  = 8'hA8,
    parameter logic [7:0] PRI_ADDR = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_stb,
    input  logic [NSRC-1:0]  src_req,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             reti
);
    logic [NSRC-1:0] en_mask, prio, pend_q, elig;
    logic            glob_en;
    logic            insvc_hi, insvc_lo;
    logic            allow_hi, allow_lo, grant;
    pick_t           picks [2];
    pick_t           sel;
    logic            req_q, lvl_q;
    logic [VEC_W-1:0] vec_q;

    irq_regs #(.EN_ADDR(EN_ADDR), .PRI_ADDR(PRI_ADDR)) regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_mask(en_mask), .glob_en(glob_en), .prio(prio)
    );

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= '0;
        else if (cyc_stb) pend_q <= src_req;
    end

    assign elig = pend_q & en_mask & {NSRC{glob_en}};

    for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
        irq_arbiter arb_i (
            .cand  (lv == 1 ? (elig & prio) : (elig & ~prio)),
            .lvl_hi(lv == 1),
            .pick  (picks[lv])
        );
    end

    assign allow_hi = picks[1].valid && !insvc_hi;
    assign allow_lo = picks[0].valid && !insvc_hi && !insvc_lo;
    assign grant    = !req_q && !reti && (allow_hi || allow_lo);
    assign sel      = allow_hi ? picks[1] : picks[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            lvl_q <= 1'b0;
            vec_q <= '0;
        end else if (req_q) begin
            if (irq_ack) req_q <= 1'b0;
        end else if (grant) begin
            req_q <= 1'b1;
            lvl_q <= sel.hi;
            vec_q <= vec_of(sel.idx);
        end
    end

    irq_level_tracker trk_i (
        .clk(clk), .rst(rst),
        .set_hi(req_q && irq_ack && lvl_q),
        .set_lo(req_q && irq_ack && !lvl_q),
        .reti(reti),
        .insvc_hi(insvc_hi), .insvc_lo(insvc_lo)
    );

    assign irq_req = req_q;
    assign irq_vec = vec_q;

    // R11
    vec_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R11
    ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R7
    nesting_rule_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (!insvc_hi && (lvl_q || !insvc_lo)));

    // R9
    reti_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !irq_req) |=> !irq_req);

    // R4
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !glob_en) |=> !irq_req);
endmodule

// File: tb/irq_vector_ctl_tb_top.sv
module irq_vector_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_stb = 1'b0;
    logic [5:0]  src_req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_vector_ctl dut_i (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .src_req(src_req),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .reti(reti)
    );

    // en, pri, req, expect request, expect vector
    localparam logic [38:0] TBL [0:11] = '{
        {8'h81, 8'h00, 6'h01, 1'b1, 16'h0003},
        {8'h82, 8'h00, 6'h02, 1'b1, 16'h000B},
        {8'h84, 8'h00, 6'h04, 1'b1, 16'h0013},
        {8'h88, 8'h00, 6'h08, 1'b1, 16'h001B},
        {8'h90, 8'h00, 6'h10, 1'b1, 16'h0023},
        {8'hA0, 8'h00, 6'h20, 1'b1, 16'h002B},
        {8'hBF, 8'h00, 6'h3F, 1'b1, 16'h0003},
        {8'hBF, 8'h00, 6'h3C, 1'b1, 16'h0013},
        {8'hBF, 8'h20, 6'h3F, 1'b1, 16'h002B},
        {8'hBF, 8'h28, 6'h3F, 1'b1, 16'h001B},
        {8'h3F, 8'h00, 6'h3F, 1'b0, 16'h0000},
        {8'hBE, 8'h00, 6'h01, 1'b0, 16'h0000}
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc_stb = 0; src_req = 0; bus_wr = 0; irq_ack = 0; reti = 0;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    task automatic strobe(input logic [5:0] r);
        src_req = r; cyc_stb = 1'b1;
        cyc();
        cyc_stb = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; cyc(); reti = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd_chk("R1 enable reg", 8'hA8, 8'h00);
        rd_chk("R1 priority reg", 8'hB8, 8'h00);
        chk("R1 irq_req", {15'd0, irq_req}, 16'd0);
        chk("R1 irq_vec", irq_vec, 16'h0000);

        // R2 register map and unused bits
        wr(8'hA8, 8'hFF);
        rd_chk("R2 enable unused bit", 8'hA8, 8'hBF);
        rd_chk("R2 priority untouched", 8'hB8, 8'h00);
        wr(8'hB8, 8'hFF);
        rd_chk("R2 priority unused bits", 8'hB8, 8'h3F);
        rd_chk("R2 enable untouched", 8'hA8, 8'hBF);

        // Table: R3 vectors, R4 masking, R5 level order, R6 index order
        for (int i = 0; i < 12; i++) begin
            do_reset();
            wr(8'hA8, TBL[i][38:31]);
            wr(8'hB8, TBL[i][30:23]);
            strobe(TBL[i][22:17]);
            cyc();
            chk($sformatf("R3/R4/R5/R6 row %0d request", i), {15'd0, irq_req}, {15'd0, TBL[i][16]});
            if (TBL[i][16]) begin
                chk($sformatf("R3/R5/R6 row %0d vector", i), irq_vec, TBL[i][15:0]);
                pulse_ack();
            end
            strobe(6'h00);
            pulse_reti();
        end

        // R10 and R12: sampling only on strobe, latency
        do_reset();
        wr(8'hA8, 8'h81);
        src_req = 6'h01;
        cyc(); cyc(); cyc();
        chk("R10 no strobe no request", {15'd0, irq_req}, 16'd0);
        strobe(6'h01);
        chk("R12 not after strobe edge", {15'd0, irq_req}, 16'd0);
        cyc();
        chk("R12 raised one edge later", {15'd0, irq_req}, 16'd1);
        // R11 hold without ack
        src_req = 6'h00;
        cyc(); cyc(); cyc();
        chk("R11 request held", {15'd0, irq_req}, 16'd1);
        chk("R11 vector held", irq_vec, 16'h0003);
        pulse_ack();
        chk("R11 dropped after ack", {15'd0, irq_req}, 16'd0);

        // R7 / R8 nesting
        do_reset();
        wr(8'hA8, 8'hBF);
        wr(8'hB8, 8'h20);
        strobe(6'h01); cyc();
        chk("R7 low granted", irq_vec, 16'h0003);
        pulse_ack();
        strobe(6'h03); cyc(); cyc();
        chk("R7 low blocked by low", {15'd0, irq_req}, 16'd0);
        strobe(6'h23); cyc();
        chk("R7 high preempts low", {15'd0, irq_req}, 16'd1);
        chk("R7 high vector", irq_vec, 16'h002B);
        pulse_ack();
        strobe(6'h23); cyc(); cyc();
        chk("R7 high blocks all", {15'd0, irq_req}, 16'd0);
        strobe(6'h03);
        pulse_reti(); cyc(); cyc();
        chk("R8 low still in service", {15'd0, irq_req}, 16'd0);
        pulse_reti(); cyc();
        chk("R8 second reti frees low", {15'd0, irq_req}, 16'd1);
        chk("R8 low vector", irq_vec, 16'h0003);
        pulse_ack();

        // R9 grant suppressed in reti cycle
        do_reset();
        wr(8'hA8, 8'h81);
        strobe(6'h01);
        reti = 1'b1; cyc(); reti = 1'b0;
        chk("R9 no grant in reti cycle", {15'd0, irq_req}, 16'd0);
        cyc();
        chk("R9 grant next cycle", {15'd0, irq_req}, 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule